// File: doc/BRIEF.md
# ADC sample format conversion bridge

This block adapts data between three parts of a sampled-signal chain. A 12-bit successive-approximation converter delivers unsigned codes with a valid strobe. A 16-bit filter expects left-aligned words. An 8-bit unsigned DAC consumes the filter results. The bridge reformats each converter code and queues the words in a four-entry buffer. A DMA-style request/acknowledge pair drains that buffer. The bridge also turns each filter result into a DAC byte.

A mode pin selects between two pairings:
- **Signed pairing:** codes are re-centred around mid-scale and scaled to fill a full signed 16-bit word. The filter result is re-biased back to an unsigned byte.
- **Unsigned pairing:** codes stay unsigned and are scaled by one bit less. The filter runs at a gain of two, and its upper byte goes straight to the DAC.

Either pairing gives the DAC a full-scale swing. A new mode is adopted only while the buffer is empty, so the two word formats never mix in the queue.

Top module: `adc_fmt_bridge`

## Requirements
- R1: While reset is held and on the first cycle after it, `fifo_req`, `ovf_flag` and `dac_valid` are 0, and `dac_code` is 0x00.
- R2: In signed mode (`mode_act`=1), a sample s is stored as {~s[11], s[10:0], 4'b0000}, which is (s-2048)<<4 in two's complement. Examples: 0→0x8000, 2048→0x0000, 4095→0x7FF0.
- R3: In unsigned mode (`mode_act`=0), a sample s is stored as {1'b0, s, 3'b000}. Example: 4095→0x7FF8.
- R4: The buffer is first-in first-out and holds 4 words.
  - `fifo_req` is 1 exactly when the buffer is not empty, and `fifo_word` shows the oldest word.
  - Each cycle with `fifo_ack`=1 removes that word.
  - An acknowledge while the buffer is empty has no effect.
- R5: Overflow handling:
  - A sample strobe that finds the buffer full, with no acknowledge in the same cycle, is discarded and sets `ovf_flag`.
  - `ovf_flag` stays 1 until a cycle with `ovf_clr`=1.
  - When `ovf_clr` and an overflow fall in the same cycle, setting wins.
- R6: `mode_act` follows `mode_sel` only at a clock edge where the buffer is empty and no sample strobe is present. While words are queued, `mode_act` holds.
- R7: In signed mode, a filter result d produces `dac_code` = {~d[15], d[14:8]}. So 0x8000→0x00 and 0x7FFF→0xFF.
- R8: In unsigned mode, a filter result d produces `dac_code` = d[15:8].
- R9: Timing:
  - A sample strobed in cycle n is visible at the buffer head (`fifo_req`=1) in cycle n+1.
  - A filter result strobed in cycle n appears on `dac_code` with `dac_valid`=1 in cycle n+1, and `dac_valid` lasts one cycle per strobe.
- R10: `dac_code` keeps its last value in cycles that follow no filter strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested format: 1 signed, 0 unsigned |
| mode_act | output | 1 | Format currently applied |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 12 | Unsigned converter code |
| fifo_req | output | 1 | Transfer request, buffer not empty |
| fifo_ack | input | 1 | Transfer acknowledge, pops one word |
| fifo_word | output | 16 | Oldest buffered word |
| ovf_flag | output | 1 | Sticky overflow indication |
| ovf_clr | input | 1 | Clears the overflow flag |
| flt_valid | input | 1 | Filter result strobe |
| flt_data | input | 16 | Filter result |
| dac_valid | output | 1 | DAC byte strobe |
| dac_code | output | 8 | Unsigned DAC byte |

## Verification
Every result of the block is due exactly one cycle after its stimulus:
- A strobed sample reaches the buffer head at the next edge.
- A filter result reaches the DAC byte at the next edge.
- A mode change waits for an empty buffer, then takes one more edge.

The bench drives inputs just after a rising edge and samples at the following falling edge, so each check lands in the first cycle where the result is due. Expected buffer words and DAC bytes are queued by the drivers, using the format the bench predicts from the mode sequence. Monitors compare them at the acknowledge cycle and at the `dac_valid` cycle, which also catches a missing or extra strobe.

// File: rtl/adc_fmt_bridge.sv
module adc_fmt_bridge #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mode_sel,
  output logic        mode_act,
  input  logic        smp_valid,
  input  logic [11:0] smp_data,
  output logic        fifo_req,
  input  logic        fifo_ack,
  output logic [15:0] fifo_word,
  output logic        ovf_flag,
  input  logic        ovf_clr,
  input  logic        flt_valid,
  input  logic [15:0] flt_data,
  output logic        dac_valid,
  output logic [7:0]  dac_code
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [15:0]   mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          unused_lo;

  wire empty = (count == '0);
  wire full  = (count == CW'(DEPTH));
  wire pop   = fifo_ack && !empty;
  wire push  = smp_valid && (!full || pop);

  wire [15:0] in_word = mode_act ? {~smp_data[11], smp_data[10:0], 4'b0000}
                                 : {1'b0, smp_data, 3'b000};
  wire [7:0]  out_byte = mode_act ? {~flt_data[15], flt_data[14:8]}
                                  : flt_data[15:8];

  wire [PW-1:0] wr_nxt = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
  wire [PW-1:0] rd_nxt = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;

  assign fifo_req  = !empty;
  assign fifo_word = mem[rd_ptr];
  assign unused_lo = ^flt_data[7:0];

  always_ff @(posedge clk)
    if (push) mem[wr_ptr] <= in_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      count     <= '0;
      ovf_flag  <= 1'b0;
      mode_act  <= 1'b0;
      dac_valid <= 1'b0;
      dac_code  <= 8'h00;
    end else begin
      if (push) wr_ptr <= wr_nxt;
      if (pop)  rd_ptr <= rd_nxt;
      count <= count + CW'(push) - CW'(pop);
      if (smp_valid && !push) ovf_flag <= 1'b1;
      else if (ovf_clr)       ovf_flag <= 1'b0;
      if (empty && !smp_valid) mode_act <= mode_sel;
      dac_valid <= flt_valid;
      if (flt_valid) dac_code <= out_byte;
    end
  end
endmodule

// File: rtl/adc_fmt_bridge_chk.sv
module adc_fmt_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        mode_act,
  input logic        smp_valid,
  input logic        fifo_req,
  input logic        fifo_ack,
  input logic [15:0] fifo_word,
  input logic        ovf_flag,
  input logic        ovf_clr,
  input logic        flt_valid,
  input logic [15:0] flt_data,
  input logic        dac_valid,
  input logic [7:0]  dac_code
);
  AST_REQ_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |=> fifo_req); // R9
  AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n) fifo_req && !fifo_ack |=> fifo_req && $stable(fifo_word)); // R4
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) ovf_flag && !ovf_clr |=> ovf_flag); // R5
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) fifo_req |=> $stable(mode_act)); // R6
  AST_DAC_SIGNED: assert property (@(posedge clk) disable iff (!rst_n) flt_valid && mode_act |=> dac_code == {~$past(flt_data[15]), $past(flt_data[14:8])}); // R7
  AST_DAC_UNSIGNED: assert property (@(posedge clk) disable iff (!rst_n) flt_valid && !mode_act |=> dac_code == $past(flt_data[15:8])); // R8
  AST_DAC_STROBE: assert property (@(posedge clk) disable iff (!rst_n) flt_valid |=> dac_valid); // R9
  AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !flt_valid |=> !dac_valid && $stable(dac_code)); // R10
endmodule

bind adc_fmt_bridge adc_fmt_bridge_chk u_chk (.*);

// File: tb/adc_fmt_bridge_bench.sv
module adc_fmt_bridge_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mode_sel = 1'b1, smp_valid = 1'b0, fifo_ack = 1'b0, ovf_clr = 1'b0, flt_valid = 1'b0;
  logic [11:0] smp_data = '0;
  logic [15:0] flt_data = '0;
  logic mode_act, fifo_req, ovf_flag, dac_valid;
  logic [15:0] fifo_word;
  logic [7:0] dac_code;

  int checks = 0, failures = 0, mcnt = 0;
  bit exp_mode = 1'b1, done = 1'b0;
  logic [15:0] word_q[$];
  logic [7:0]  dac_q[$];

  adc_fmt_bridge u_adc_fmt_bridge (.*);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic logic [15:0] fmt(input logic [11:0] s);
    return exp_mode ? {~s[11], s[10:0], 4'b0000} : {1'b0, s, 3'b000};
  endfunction

  task automatic put_sample(input logic [11:0] s);
    smp_valid = 1'b1; smp_data = s;
    if (mcnt < 4) begin word_q.push_back(fmt(s)); mcnt++; end
    step();
    smp_valid = 1'b0;
    @(negedge clk);
    chk(fifo_req === 1'b1, "R9 req after sample", fifo_req, 1);
    step();
  endtask

  task automatic pop();
    fifo_ack = 1'b1;
    if (mcnt > 0) mcnt--;
    step();
    fifo_ack = 1'b0;
  endtask

  task automatic put_flt(input logic [15:0] d);
    flt_valid = 1'b1; flt_data = d;
    dac_q.push_back(exp_mode ? {~d[15], d[14:8]} : d[15:8]);
    step();
    flt_valid = 1'b0;
  endtask

  always @(negedge clk) if (rst_n && fifo_ack) begin
    if (word_q.size() == 0)
      chk(fifo_req === 1'b0, "R4 ack on empty buffer", fifo_req, 0);
    else begin
      logic [15:0] e;
      e = word_q.pop_front();
      chk(fifo_req === 1'b1 && fifo_word === e, "R2/R3/R4 buffered word", fifo_word, e);
    end
  end

  always @(negedge clk) if (rst_n && dac_valid) begin
    if (dac_q.size() == 0) chk(1'b0, "R9 unexpected dac_valid", dac_code, 0);
    else begin
      logic [7:0] e;
      e = dac_q.pop_front();
      chk(dac_code === e, "R7/R8 dac byte", dac_code, e);
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(fifo_req === 1'b0 && ovf_flag === 1'b0 && dac_valid === 1'b0, "R1 reset outputs", {fifo_req, ovf_flag, dac_valid}, 0);
    chk(dac_code === 8'h00, "R1 reset dac_code", dac_code, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(fifo_req === 1'b0 && ovf_flag === 1'b0, "R1 after reset", {fifo_req, ovf_flag}, 0);
    step(); step();
    chk(mode_act === 1'b1, "R6 empty buffer adopts mode", mode_act, 1);

    // R2 signed formatting and R4 ordering
    put_sample(12'd0); put_sample(12'd2048); put_sample(12'd4095); put_sample(12'h123);
    repeat (4) pop();
    @(negedge clk);
    chk(fifo_req === 1'b0, "R4 empty after drain", fifo_req, 0);
    step();
    pop();
    put_sample(12'h7FF);
    pop();

    // R5 overflow drop and sticky flag
    put_sample(12'd1); put_sample(12'd2); put_sample(12'd3); put_sample(12'd4);
    @(negedge clk);
    chk(ovf_flag === 1'b0, "R5 no overflow at exactly full", ovf_flag, 0);
    step();
    put_sample(12'd5);
    @(negedge clk);
    chk(ovf_flag === 1'b1, "R5 overflow set", ovf_flag, 1);
    repeat (3) step();
    chk(ovf_flag === 1'b1, "R5 overflow sticky", ovf_flag, 1);
    ovf_clr = 1'b1; step(); ovf_clr = 1'b0;
    chk(ovf_flag === 1'b0, "R5 overflow cleared", ovf_flag, 0);
    repeat (4) pop();

    // R6 mode change deferred while words are queued
    put_sample(12'd100); put_sample(12'd200);
    mode_sel = 1'b0;
    put_sample(12'd300);
    chk(mode_act === 1'b1, "R6 mode held while queued", mode_act, 1);
    repeat (3) pop();
    step(); step();
    chk(mode_act === 1'b0, "R6 mode adopted after drain", mode_act, 0);
    exp_mode = 1'b0;

    // R3 unsigned formatting
    put_sample(12'd4095); put_sample(12'd0); put_sample(12'hABC);
    repeat (3) pop();

    // R8 unsigned output, R9 timing, R10 hold
    put_flt(16'hFFFF); put_flt(16'h1234);
    step();
    put_flt(16'h8000);
    repeat (3) step();
    @(negedge clk);
    chk(dac_valid === 1'b0 && dac_code === 8'h80, "R10 dac hold", dac_code, 8'h80);
    step();

    // R7 signed output
    mode_sel = 1'b1;
    step(); step();
    chk(mode_act === 1'b1, "R6 back to signed", mode_act, 1);
    exp_mode = 1'b1;
    put_flt(16'h8000); put_flt(16'h7FFF); put_flt(16'h0000); put_flt(16'hFF00);
    repeat (3) step();

    chk(word_q.size() == 0, "R4 all words delivered", word_q.size(), 0);
    chk(dac_q.size() == 0, "R9 all dac bytes delivered", dac_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule